// File: doc/BRIEF.md
# Horizontal Polyphase Pixel Scaler

This block resamples one video line at a time along the horizontal axis. Input pixels enter as an 8-bit stream with valid/ready handshake and an end-of-line marker. The block keeps a four-pixel sliding window in registers and walks a fixed-point position across the line. For every output pixel it picks one of sixteen coefficient sets from the fractional part of that position, forms a four-tap weighted sum, then rounds and clamps the result to the pixel range. The output leaves on an 8-bit stream that has the same handshake and end-of-line marker.

Two quasi-static inputs set the work. The step is the distance between successive output pixels, measured in input pixels. It is the ratio of input width to output width. The output width is the number of pixels to emit per line. A step below one enlarges the line and a step above one shrinks it. The weighted sum runs through a three-stage pipeline of parallel multipliers and an adder tree. When the output is stalled, the whole block stalls with it.

Top module: `hpoly_scaler`

## Requirements
- R1: After reset, and while idle between lines, `out_valid` is 0 and `in_ready` is 1 (unless the output is stalled). A reset in the middle of a line drops that line.
- R2: Let `x[i]` be the input pixels of the line. Output k uses the pixels at indices ip-1, ip, ip+1 and ip+2, with weights c0..c3 for phase p. With t = p/16, c0 = floor(64(-t³+2t²-t)), c2 = floor(64(-3t³+4t²+t)), c3 = floor(64(t³-t²)) and c1 = 128-c0-c2-c3. The sum is Σ c·x.
- R3: `cfg_step` is unsigned 4.12 fixed point. Output k sits at position P = k·cfg_step, with ip = P>>12 and phase p = P[11:8]. A step of exactly 1.0 (0x1000) reproduces the input pixels unchanged.
- R4: An index below 0 reads the first pixel of the line. An index beyond the last one reads the last pixel. A line of a single pixel therefore yields that pixel at every output.
- R5: Each line yields exactly `cfg_out_width` output pixels. `out_eol` is 1 on the last of them and 0 on all the others. No further output follows until the next line starts.
- R6: The result is (Σ c·x + 64) >> 7, using an arithmetic shift. Negative results become 0 and results above 255 become 255.
- R7: The block accepts every input pixel of a line, including the one marked `in_eol`. Pixels that arrive after the last output has been produced are consumed and discarded, so the next line starts aligned.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_pixel` and `out_eol` hold their values and `in_ready` is 0.
- R9: With a continuous input and `out_ready` held at 1, the first output of a line is visible after the 6th rising edge, counting the edge that accepts the line's first pixel as the 1st.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_step | input | 16 | Output pixel spacing, unsigned 4.12 |
| cfg_out_width | input | 12 | Output pixels per line, at least 1 |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_pixel | input | 8 | Input pixel value |
| in_eol | input | 1 | Marks the last input pixel of a line |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_pixel | output | 8 | Output pixel value |
| out_eol | output | 1 | Marks the last output pixel of a line |

## Verification
The bench runs lines that enlarge, keep the same size and shrink them, and it aims at the line edges. A design that clamps indices wrongly gives wrong values at the first and last outputs. It also gives wrong values on a one-pixel line, where every output must equal that pixel. Alternating black and white pairs make the filter overshoot in both directions, which exposes any missing clamp or a wrong rounding offset. A shrinking line that carries more pixels than it needs checks that the surplus is discarded: a design that leaves it unconsumed hangs, or shifts the next line. Output stalls of varying length check that a held pixel never changes and that no input slips in during the stall.

// File: rtl/hps_pkg.sv
// Shared constants, state type and coefficient generator for the horizontal scaler.
// Assumes: four taps; the coefficient formula is a cubic convolution kernel.
package hps_pkg;

    localparam int NTAPS = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } fe_state_e;

    // Weight of one tap for one phase, scaled by 2**cf_bits; the centre tap
    // absorbs the truncation so every set sums to exactly unity gain.
    function automatic int hps_coef(input int ph, input int tap,
                                    input int ph_bits, input int cf_bits);
        int sh;
        int p1;
        int p2;
        int p3;
        int c0;
        int c2;
        int c3;
        sh = 1 + 3 * ph_bits - cf_bits;
        p1 = ph << (2 * ph_bits);
        p2 = (ph * ph) << (ph_bits + 1);
        p3 = ph * ph * ph;
        c0 = (-p3 + p2 - p1) >>> sh;
        c2 = (-3 * p3 + 2 * p2 + p1) >>> sh;
        c3 = (p3 - (p2 >>> 1)) >>> sh;
        case (tap)
            0:       return c0;
            1:       return (1 << cf_bits) - c0 - c2 - c3;
            2:       return c2;
            default: return c3;
        endcase
    endfunction

endpackage

// File: rtl/hps_coef_rom.sv
// Coefficient table: one weight set per phase, filled from hps_coef at elaboration.
// Assumes: PHASE_BITS and COEF_FRAC keep the formula shift positive.
module hps_coef_rom
    import hps_pkg::*;
#(
    parameter int PHASE_BITS = 4,
    parameter int COEF_W     = 9,
    parameter int COEF_FRAC  = 7
) (
    input  logic [PHASE_BITS-1:0]          phase,
    output logic [NTAPS-1:0][COEF_W-1:0]   coefs
);

    localparam int NPHASE = 1 << PHASE_BITS;

    logic [NTAPS-1:0][COEF_W-1:0] rom [NPHASE];

    for (genvar ph = 0; ph < NPHASE; ph++) begin : g_phase
        for (genvar k = 0; k < NTAPS; k++) begin : g_tap
            assign rom[ph][k] = COEF_W'(hps_coef(ph, k, PHASE_BITS, COEF_FRAC));
        end
    end

    // Select the weight set addressed by the current phase.
    always_comb begin
        coefs = rom[phase];
    end

endmodule

// File: rtl/hps_ctrl.sv
// Front end: tap window, position accumulator and output issue control.
// Assumes: cfg_step and cfg_out_width are stable during a line, width >= 1.
// Window taps[0] holds index h-3 (oldest), taps[NTAPS-1] holds index h.
module hps_ctrl
    import hps_pkg::*;
#(
    parameter int PIX_W      = 8,
    parameter int STEP_W     = 16,
    parameter int FRAC_W     = 12,
    parameter int PHASE_BITS = 4,
    parameter int LINE_W     = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           adv,
    input  logic [STEP_W-1:0]              cfg_step,
    input  logic [LINE_W-1:0]              cfg_width,
    input  logic                           in_valid,
    input  logic [PIX_W-1:0]               in_pixel,
    input  logic                           in_eol,
    output logic                           in_ready,
    output logic                           iss_valid,
    output logic [NTAPS-1:0][PIX_W-1:0]    iss_taps,
    output logic [PHASE_BITS-1:0]          iss_phase,
    output logic                           iss_last
);

    localparam int POS_W = LINE_W + FRAC_W;
    localparam int IDX_W = LINE_W + 2;

    fe_state_e                    state;
    logic [NTAPS-1:0][PIX_W-1:0]  taps;
    logic [POS_W-1:0]             pos;
    logic [IDX_W-1:0]             h;
    logic [IDX_W-1:0]             need;
    logic [LINE_W-1:0]            cnt;
    logic                         eol_seen;
    logic                         want_px;
    logic                         take;

    // Decide whether the window must advance or an output can be issued.
    always_comb begin
        need      = {2'b00, pos[POS_W-1 -: LINE_W]} + IDX_W'(2);
        want_px   = (state == ST_RUN) && (h < need);
        in_ready  = adv && ((state == ST_IDLE) || (state == ST_FLUSH) ||
                            (want_px && !eol_seen));
        take      = in_valid && in_ready;
        iss_valid = adv && (state == ST_RUN) && !want_px;
        iss_last  = iss_valid && (cnt == cfg_width - LINE_W'(1));
        iss_taps  = taps;
        iss_phase = pos[FRAC_W-1 -: PHASE_BITS];
    end

    // Window, position and line-state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            taps     <= '0;
            pos      <= '0;
            h        <= '0;
            cnt      <= '0;
            eol_seen <= 1'b0;
        end else if (adv) begin
            case (state)
                ST_IDLE: begin
                    if (take) begin
                        taps     <= {NTAPS{in_pixel}};
                        pos      <= '0;
                        h        <= '0;
                        cnt      <= '0;
                        eol_seen <= in_eol;
                        state    <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (want_px) begin
                        if (!eol_seen) begin
                            if (take) begin
                                taps     <= {in_pixel, taps[NTAPS-1:1]};
                                h        <= h + IDX_W'(1);
                                eol_seen <= in_eol;
                            end
                        end else begin
                            taps <= {taps[NTAPS-1], taps[NTAPS-1:1]};
                            h    <= h + IDX_W'(1);
                        end
                    end else begin
                        pos <= pos + POS_W'(cfg_step);
                        cnt <= cnt + LINE_W'(1);
                        if (iss_last) begin
                            state <= eol_seen ? ST_IDLE : ST_FLUSH;
                        end
                    end
                end
                ST_FLUSH: begin
                    if (take && in_eol) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4: the window never runs ahead of the pixels the current output needs.
    a_r4_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (h <= need));

    // R5: the issue count stays below the configured width inside a line.
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (cnt < cfg_width));

    // R7: discarding only happens for a line whose end marker is still due.
    a_r7_flush_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH) |-> !eol_seen);

endmodule

// File: rtl/hps_mac.sv
// Three-stage multiply-accumulate: parallel products, pairwise adder tree,
// final sum with round-half-up and clamp to the pixel range.
// Assumes: adv low freezes every stage (global stall).
module hps_mac
    import hps_pkg::*;
#(
    parameter int PIX_W     = 8,
    parameter int COEF_W    = 9,
    parameter int COEF_FRAC = 7
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           adv,
    input  logic                           in_valid,
    input  logic [NTAPS-1:0][PIX_W-1:0]    in_taps,
    input  logic [NTAPS-1:0][COEF_W-1:0]   in_coefs,
    input  logic                           in_last,
    output logic                           out_valid,
    output logic [PIX_W-1:0]               out_pixel,
    output logic                           out_last
);

    localparam int PRD_W   = PIX_W + 1 + COEF_W;
    localparam int SUM_W   = PRD_W + 1;
    localparam int ACC_W   = SUM_W + 1;
    localparam int NPAIR   = NTAPS / 2;
    localparam int PIX_MAX = (1 << PIX_W) - 1;

    logic signed [PRD_W-1:0] prod [NTAPS];
    logic signed [SUM_W-1:0] sum2 [NPAIR];
    logic signed [ACC_W-1:0] total;
    logic signed [ACC_W-1:0] scaled;
    logic [PIX_W-1:0]        pix_next;
    logic                    v1;
    logic                    v2;
    logic                    l1;
    logic                    l2;

    // Stage 1: all tap products in parallel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0;
            l1 <= 1'b0;
            for (int k = 0; k < NTAPS; k++) prod[k] <= '0;
        end else if (adv) begin
            v1 <= in_valid;
            l1 <= in_last;
            for (int k = 0; k < NTAPS; k++) begin
                prod[k] <= $signed({1'b0, in_taps[k]}) * $signed(in_coefs[k]);
            end
        end
    end

    // Stage 2: first level of the adder tree, one adder per tap pair.
    for (genvar j = 0; j < NPAIR; j++) begin : g_pair
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sum2[j] <= '0;
            end else if (adv) begin
                sum2[j] <= SUM_W'(prod[2*j]) + SUM_W'(prod[2*j+1]);
            end
        end
    end

    // Stage 2 control: valid and end-of-line follow the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2 <= 1'b0;
            l2 <= 1'b0;
        end else if (adv) begin
            v2 <= v1;
            l2 <= l1;
        end
    end

    // Final sum, rounding offset, arithmetic shift and clamp.
    always_comb begin
        total  = ACC_W'(sum2[0]) + ACC_W'(sum2[1]);
        scaled = (total + ACC_W'(1 <<< (COEF_FRAC - 1))) >>> COEF_FRAC;
        if (scaled < 0) begin
            pix_next = '0;
        end else if (scaled > ACC_W'(PIX_MAX)) begin
            pix_next = PIX_W'(PIX_MAX);
        end else begin
            pix_next = scaled[PIX_W-1:0];
        end
    end

    // Stage 3: registered output pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_pixel <= '0;
        end else if (adv) begin
            out_valid <= v2;
            out_last  <= l2;
            out_pixel <= pix_next;
        end
    end

    // R9: an issued product moves to the adder stage on the next advancing edge.
    a_r9_stage_flow: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && v1) |=> v2);

    // R9: a frozen pipeline keeps its last stage unchanged.
    a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(out_valid) && $stable(out_pixel)));

endmodule

// File: rtl/hpoly_scaler.sv
// Horizontal polyphase pixel scaler top: front end, coefficient table and MAC.
// Assumes: configuration changes only between lines; output width >= 1.
module hpoly_scaler
    import hps_pkg::*;
#(
    parameter int PIX_W      = 8,
    parameter int STEP_W     = 16,
    parameter int FRAC_W     = 12,
    parameter int PHASE_BITS = 4,
    parameter int LINE_W     = 12,
    parameter int COEF_W     = 9,
    parameter int COEF_FRAC  = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STEP_W-1:0]  cfg_step,
    input  logic [LINE_W-1:0]  cfg_out_width,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [PIX_W-1:0]   in_pixel,
    input  logic               in_eol,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [PIX_W-1:0]   out_pixel,
    output logic               out_eol
);

    logic                         adv;
    logic                         iss_valid;
    logic                         iss_last;
    logic [NTAPS-1:0][PIX_W-1:0]  iss_taps;
    logic [PHASE_BITS-1:0]        iss_phase;
    logic [NTAPS-1:0][COEF_W-1:0] coefs;

    // Whole-block advance: frozen while an output waits for the consumer.
    always_comb begin
        adv = !(out_valid && !out_ready);
    end

    hps_ctrl #(
        .PIX_W      (PIX_W),
        .STEP_W     (STEP_W),
        .FRAC_W     (FRAC_W),
        .PHASE_BITS (PHASE_BITS),
        .LINE_W     (LINE_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .cfg_step  (cfg_step),
        .cfg_width (cfg_out_width),
        .in_valid  (in_valid),
        .in_pixel  (in_pixel),
        .in_eol    (in_eol),
        .in_ready  (in_ready),
        .iss_valid (iss_valid),
        .iss_taps  (iss_taps),
        .iss_phase (iss_phase),
        .iss_last  (iss_last)
    );

    hps_coef_rom #(
        .PHASE_BITS (PHASE_BITS),
        .COEF_W     (COEF_W),
        .COEF_FRAC  (COEF_FRAC)
    ) u_rom (
        .phase (iss_phase),
        .coefs (coefs)
    );

    hps_mac #(
        .PIX_W     (PIX_W),
        .COEF_W    (COEF_W),
        .COEF_FRAC (COEF_FRAC)
    ) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .in_valid  (iss_valid),
        .in_taps   (iss_taps),
        .in_coefs  (coefs),
        .in_last   (iss_last),
        .out_valid (out_valid),
        .out_pixel (out_pixel),
        .out_last  (out_eol)
    );

    // R8: a refused output stays put until it is taken.
    a_r8_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_pixel) && $stable(out_eol)));

    // R8: no input is taken while the output is refused.
    a_r8_no_intake: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/hpoly_scaler_tb.sv
// Self-checking bench: a case table walked by one loop, then directed
// reset tests. Inputs change 1 time unit after a rising edge; handshakes
// and outputs are sampled on the falling edge.
module hpoly_scaler_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCASE      = 8;
    localparam int MAXPX      = 64;

    // {step 4.12, out width, in length, pattern, ready mode}
    localparam logic [47:0] CASES [NCASE] = '{
        {16'h1000, 12'd8,  12'd8,  4'd0, 4'd0},  // unity step, identity
        {16'h0800, 12'd16, 12'd8,  4'd1, 4'd0},  // 2x enlarge, overshoot
        {16'h2000, 12'd4,  12'd8,  4'd2, 4'd1},  // 2x shrink
        {16'h0A00, 12'd12, 12'd7,  4'd1, 4'd2},  // enlarge, long stalls
        {16'h1800, 12'd5,  12'd10, 4'd2, 4'd1},  // surplus input pixels
        {16'h0400, 12'd6,  12'd1,  4'd0, 4'd0},  // one-pixel line
        {16'h0C00, 12'd9,  12'd3,  4'd2, 4'd2},  // runs past the line end
        {16'h1340, 12'd10, 12'd12, 4'd2, 4'd1}   // odd fraction
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_step = 16'h1000;
    logic [11:0] cfg_out_width = 12'd1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_pixel = 8'd0;
    logic        in_eol = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_pixel;
    logic        out_eol;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ngot = 0;
    int first_in = -1;
    int first_out = -1;
    int line_len = 0;
    int line_step = 0;
    logic       in_fire = 1'b0;
    logic       prev_stall = 1'b0;
    logic [7:0] stall_px = 8'd0;
    logic       stall_eol = 1'b0;
    logic [7:0] line_px [MAXPX];
    logic [7:0] got_px [MAXPX];
    logic       got_eol [MAXPX];

    hpoly_scaler u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_step      (cfg_step),
        .cfg_out_width (cfg_out_width),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_pixel      (in_pixel),
        .in_eol        (in_eol),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_pixel     (out_pixel),
        .out_eol       (out_eol)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Falling-edge sampler: handshakes, collected outputs, stall behaviour (R8).
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            in_fire    = 1'b0;
            prev_stall = 1'b0;
        end else begin
            in_fire = in_valid && in_ready;
            if (in_fire && first_in < 0) first_in = cyc;
            if (out_valid && first_out < 0) first_out = cyc;
            if (prev_stall) begin
                checks++;
                if (!(out_valid && out_pixel == stall_px && out_eol == stall_eol)) begin
                    errors++;
                    $display("FAIL R8 stall hold: got v=%0d px=%0d eol=%0d exp v=1 px=%0d eol=%0d",
                             out_valid, out_pixel, out_eol, stall_px, stall_eol);
                end
            end
            if (out_valid && !out_ready) begin
                checks++;
                if (in_ready !== 1'b0) begin
                    errors++;
                    $display("FAIL R8 intake during stall: got in_ready=%0d exp 0", in_ready);
                end
            end
            prev_stall = out_valid && !out_ready;
            stall_px   = out_pixel;
            stall_eol  = out_eol;
            if (out_valid && out_ready && ngot < MAXPX) begin
                got_px[ngot]  = out_pixel;
                got_eol[ngot] = out_eol;
                ngot = ngot + 1;
            end
        end
    end

    function automatic logic [7:0] pat_px(input int pat, input int i);
        case (pat)
            0:       return 8'((i * 29 + 3) & 255);
            1:       return ((i >> 1) & 1) != 0 ? 8'd255 : 8'd0;
            default: return 8'((i * 97 + 41) % 251);
        endcase
    endfunction

    // Expected output k from the requirement formulas (R2, R3, R4, R6).
    function automatic int model_px(input int k);
        int  p;
        int  ip;
        int  ph;
        int  idx;
        int  c [4];
        int  acc;
        int  v;
        real t;
        p  = k * line_step;
        ip = p >> 12;
        ph = (p >> 8) & 15;
        t  = ph / 16.0;
        c[0] = int'($floor(64.0 * (-t * t * t + 2.0 * t * t - t)));
        c[2] = int'($floor(64.0 * (-3.0 * t * t * t + 4.0 * t * t + t)));
        c[3] = int'($floor(64.0 * (t * t * t - t * t)));
        c[1] = 128 - c[0] - c[2] - c[3];
        acc = 0;
        for (int j = 0; j < 4; j++) begin
            idx = ip - 1 + j;
            if (idx < 0) idx = 0;
            if (idx > line_len - 1) idx = line_len - 1;
            acc = acc + c[j] * int'(line_px[idx]);
        end
        v = int'($floor((acc + 64) / 128.0));
        if (v < 0) v = 0;
        if (v > 255) v = 255;
        return v;
    endfunction

    function automatic string tag_of(input int c);
        case (c)
            1, 3:    return "R6";
            2, 4, 7: return "R3";
            5, 6:    return "R4";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d exp %0d", tag, what, got, exp);
        end
    endtask

    // Send one line under the given configuration and compare every output.
    task automatic run_case(input int c);
        logic [47:0] v;
        int w;
        int pat;
        int rmode;
        int src;
        int guard;
        v         = CASES[c];
        line_step = int'(v[47:32]);
        w         = int'(v[31:20]);
        line_len  = int'(v[19:8]);
        pat       = int'(v[7:4]);
        rmode     = int'(v[3:0]);
        for (int i = 0; i < line_len; i++) line_px[i] = pat_px(pat, i);
        cfg_step      = v[47:32];
        cfg_out_width = v[31:20];
        ngot      = 0;
        first_in  = -1;
        first_out = -1;
        src   = 0;
        guard = 0;
        while (!(src == line_len && ngot >= w) && guard < 3000) begin
            @(posedge clk);
            #1;
            if (in_fire) src++;
            in_valid = (src < line_len);
            in_pixel = (src < line_len) ? line_px[src] : 8'd0;
            in_eol   = (src == line_len - 1);
            case (rmode)
                1:       out_ready = (cyc % 3) != 0;
                2:       out_ready = (cyc % 8) < 2;
                default: out_ready = 1'b1;
            endcase
            guard++;
        end
        in_valid  = 1'b0;
        in_eol    = 1'b0;
        out_ready = 1'b1;
        repeat (8) @(posedge clk);
        #1;
        // R7: every input pixel, surplus included, has been taken.
        check("R7", $sformatf("case %0d inputs taken", c), src, line_len);
        // R5: exactly the configured number of outputs, nothing after.
        check("R5", $sformatf("case %0d output count", c), ngot, w);
        for (int k = 0; k < w && k < ngot; k++) begin
            check(tag_of(c), $sformatf("case %0d pixel %0d", c, k),
                  int'(got_px[k]), model_px(k));
            check("R5", $sformatf("case %0d eol %0d", c, k),
                  int'(got_eol[k]), (k == w - 1) ? 1 : 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD / 2);
        // R1: state under reset.
        check("R1", "out_valid in reset", int'(out_valid), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset accepts a line start.
        check("R1", "out_valid after reset", int'(out_valid), 0);
        check("R1", "in_ready after reset", int'(in_ready), 1);

        for (int c = 0; c < NCASE; c++) begin
            run_case(c);
            if (c == 0) begin
                // R9: first output six edges after the first accepted pixel.
                check("R9", "latency", first_out - first_in, 6);
            end
        end

        // R1: a reset in mid-line discards the line and returns to idle.
        cfg_step      = 16'h0800;
        cfg_out_width = 12'd16;
        in_valid = 1'b1;
        in_pixel = 8'd77;
        in_eol   = 1'b0;
        out_ready = 1'b0;
        repeat (6) @(posedge clk);
        #1 rst_n = 1'b0;
        in_valid = 1'b0;
        out_ready = 1'b1;
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_valid after mid-line reset", int'(out_valid), 0);
        check("R1", "in_ready after mid-line reset", int'(in_ready), 1);
        repeat (4) @(negedge clk);
        check("R1", "no stray output after reset", int'(out_valid), 0);
        run_case(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule